// File: doc/BRIEF.md
# Cascaded Decimal (Packed-BCD) Adder

This block adds two unsigned decimal numbers held in packed BCD, one decimal digit per 4-bit nibble, together with a one-bit carry-in. It returns the packed-BCD sum and a decimal carry-out. The number of digits is a parameter. Every digit position has its own 4-bit binary adder. A detector flags any binary result above nine, and a second adder stage then adds six to correct that digit. The flag of each digit is its decimal carry and feeds the carry-in of the next digit up, so the carries ripple from the least significant digit to the most significant one.

The operands are accepted on a cycle where `in_valid` is high. The sum and carry-out are registered and appear one clock later with `out_valid` high. On cycles without a new operand the output registers keep their contents. Operand nibbles above nine are not checked.

Top module: `bcd_cascade_adder`

## Requirements
- R1: While `rst` is high at a rising edge, `out_valid`, `sum_bcd` and `carry_out` are cleared to zero.
- R2: `out_valid` at each rising edge takes the value that `in_valid` had at the previous edge, so a result appears exactly one clock after its operands.
- R3: When `in_valid` is low at an edge, `sum_bcd` and `carry_out` keep their previous values.
- R4: A digit whose binary total (a + b + incoming carry) is nine or less passes through unchanged, with no carry to the next digit; for example 5 + 3 gives digit 8 and no carry.
- R5: A digit whose binary total is ten or more has 6 (binary 0110) added to it, truncated to 4 bits, and passes a carry of 1 to the next digit. This applies both to totals of 10 to 15 and to totals above 15. For example 7 + 6 gives digit 3 with a carry, and 9 + 9 + 1 gives digit 9 with a carry.
- R6: The decimal carry of digit i is the carry-in of digit i+1, and it can ripple through a run of nines. For example 247 + 538 gives 785, and 0999 + 0001 gives 1000.
- R7: `carry_in` is added into digit 0 only.
- R8: `carry_out` is the decimal carry of the most significant digit. For example 9999 + 9999 + 1 gives sum 9999 with `carry_out` = 1.
- R9: Digit 0 occupies bits [3:0] of each packed-BCD bus, and digit i occupies bits [4i+3:4i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands present this cycle |
| a_bcd | input | 4*DIGITS | First operand, packed BCD |
| b_bcd | input | 4*DIGITS | Second operand, packed BCD |
| carry_in | input | 1 | Carry into digit 0 |
| out_valid | output | 1 | Registered result is new |
| sum_bcd | output | 4*DIGITS | Registered packed-BCD sum |
| carry_out | output | 1 | Registered decimal carry of the top digit |

## Verification
The assertions check two things on every cycle. Each digit cell must give a correct decimal result for legal operand digits: its carry times ten plus its digit equals the operand total, and the digit stays at nine or below. At the registers, the one-cycle valid latency, the hold on idle cycles and the reset values are checked as well. Some behaviour can only be shown by the bench's scenarios, because it depends on chosen operands. This covers carries rippling across several digits, where the carry-in enters, the nibble ordering of the buses and the carry-out at full scale. The bench compares every result with a decimal reference model. It uses fixed vectors and a sweep of computed ones.

// File: rtl/bcd_add_pkg.sv
package bcd_add_pkg;

    localparam int unsigned NIBBLE_W = 4;
    localparam logic [3:0]  FIX_SIX  = 4'b0110;
    localparam logic [3:0]  MAX_DEC  = 4'd9;

    typedef logic [NIBBLE_W-1:0] nibble_t;

    typedef struct packed {
        logic    carry;
        nibble_t digit;
    } dec_digit_t;

    // Flag a 5-bit binary digit total that is not a legal decimal digit.
    function automatic logic over_nine(input logic [4:0] total);
        return total[4] | (total[3] & (total[2] | total[1]));
    endfunction

endpackage

// File: rtl/bcd_digit_cell.sv
module bcd_digit_cell
    import bcd_add_pkg::*;
(
    input  nibble_t    a_dig,
    input  nibble_t    b_dig,
    input  logic       c_in,
    output dec_digit_t res
);
    logic [4:0] raw_total;
    logic       fix_flag;

    // Stage 1: plain binary add of the two digits and the incoming carry.
    assign raw_total = {1'b0, a_dig} + {1'b0, b_dig} + {4'b0, c_in};

    // Detector: binary carry or sum in 10..15.
    assign fix_flag  = over_nine(raw_total);

    // Stage 2: add six when flagged; the carry of this adder is dropped.
    assign res.digit = raw_total[3:0] + (fix_flag ? FIX_SIX : 4'd0);
    assign res.carry = fix_flag;

    always_comb begin
        if (a_dig <= MAX_DEC && b_dig <= MAX_DEC) begin
            AST_DIGIT_VALUE: assert ((res.carry ? 5'd10 : 5'd0) + {1'b0, res.digit}
                                     == {1'b0, a_dig} + {1'b0, b_dig} + {4'b0, c_in}); // R5
            AST_DIGIT_RANGE: assert (res.digit <= MAX_DEC); // R4
        end
    end

endmodule

// File: rtl/bcd_digit_chain.sv
module bcd_digit_chain
    import bcd_add_pkg::*;
#(
    parameter int unsigned DIGITS = 4,
    localparam int unsigned BUS_W = DIGITS * NIBBLE_W
) (
    input  logic [BUS_W-1:0] a_bus,
    input  logic [BUS_W-1:0] b_bus,
    input  logic             c_first,
    output logic [BUS_W-1:0] s_bus,
    output logic             c_last
);
    logic [DIGITS:0] ripple;

    assign ripple[0] = c_first;

    for (genvar gi = 0; gi < DIGITS; gi++) begin : g_digit
        dec_digit_t cell_res;

        bcd_digit_cell u_cell (
            .a_dig (a_bus[gi*NIBBLE_W +: NIBBLE_W]),
            .b_dig (b_bus[gi*NIBBLE_W +: NIBBLE_W]),
            .c_in  (ripple[gi]),
            .res   (cell_res)
        );

        assign s_bus[gi*NIBBLE_W +: NIBBLE_W] = cell_res.digit;
        assign ripple[gi+1]                   = cell_res.carry;
    end

    assign c_last = ripple[DIGITS];

endmodule

// File: rtl/bcd_cascade_adder.sv
module bcd_cascade_adder
    import bcd_add_pkg::*;
#(
    parameter int unsigned DIGITS = 4,
    localparam int unsigned BUS_W = DIGITS * NIBBLE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [BUS_W-1:0] a_bcd,
    input  logic [BUS_W-1:0] b_bcd,
    input  logic             carry_in,
    output logic             out_valid,
    output logic [BUS_W-1:0] sum_bcd,
    output logic             carry_out
);
    logic [BUS_W-1:0] sum_comb;
    logic             carry_comb;
    logic             ran_once;

    bcd_digit_chain #(.DIGITS(DIGITS)) u_chain (
        .a_bus   (a_bcd),
        .b_bus   (b_bcd),
        .c_first (carry_in),
        .s_bus   (sum_comb),
        .c_last  (carry_comb)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            sum_bcd   <= '0;
            carry_out <= 1'b0;
            ran_once  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            ran_once  <= 1'b1;
            if (in_valid) begin
                sum_bcd   <= sum_comb;
                carry_out <= carry_comb;
            end
        end
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        $past(rst) |-> (!out_valid && sum_bcd == '0 && !carry_out)); // R1

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
        ran_once |-> (out_valid == $past(in_valid))); // R2

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(sum_bcd) && $stable(carry_out))); // R3

endmodule

// File: tb/bcd_cascade_adder_bench.sv
module bcd_cascade_adder_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DIGITS     = 4;
    localparam int BUS_W      = DIGITS * 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             in_valid = 1'b0;
    logic [BUS_W-1:0] a_bcd = '0;
    logic [BUS_W-1:0] b_bcd = '0;
    logic             carry_in = 1'b0;
    logic             out_valid;
    logic [BUS_W-1:0] sum_bcd;
    logic             carry_out;

    typedef struct {
        logic [BUS_W-1:0] sum;
        logic             cout;
        string            tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fails  = 0;
    bit   finished = 0;
    logic iv_seen  = 1'b0;
    logic have_last = 1'b0;
    logic [BUS_W-1:0] last_sum;
    logic             last_cout;

    bcd_cascade_adder #(.DIGITS(DIGITS)) u_bcd_cascade_adder (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .a_bcd(a_bcd), .b_bcd(b_bcd), .carry_in(carry_in),
        .out_valid(out_valid), .sum_bcd(sum_bcd), .carry_out(carry_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int from_bcd(input logic [BUS_W-1:0] v);
        int r = 0;
        for (int d = DIGITS - 1; d >= 0; d--) r = r * 10 + int'(v[d*4 +: 4]);
        return r;
    endfunction

    function automatic logic [BUS_W-1:0] to_bcd(input int v);
        logic [BUS_W-1:0] r = '0;
        int t = v;
        for (int d = 0; d < DIGITS; d++) begin
            r[d*4 +: 4] = 4'(t % 10);
            t = t / 10;
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    endtask

    // Driver: presents one operand set and queues the decimal reference result.
    task automatic drive(input int a, input int b, input logic ci, input string tag);
        exp_t e;
        int   total;
        int   modv;
        modv  = 1;
        for (int d = 0; d < DIGITS; d++) modv = modv * 10;
        total = a + b + int'(ci);
        e.sum  = to_bcd(total % modv);
        e.cout = (total >= modv);
        e.tag  = tag;
        @(posedge clk); #1;
        a_bcd = to_bcd(a); b_bcd = to_bcd(b); carry_in = ci; in_valid = 1'b1;
        exp_q.push_back(e);
    endtask

    task automatic idle(input int cycles);
        for (int k = 0; k < cycles; k++) begin
            @(posedge clk); #1;
            in_valid = 1'b0;
            a_bcd = to_bcd(1234); b_bcd = to_bcd(4321); carry_in = 1'b1;
        end
    endtask

    always @(posedge clk) iv_seen <= in_valid;

    // Monitor: compares registered outputs away from the active edge.
    always @(negedge clk) begin
        if (!rst) begin
            check("R2 out_valid latency", 64'(out_valid), 64'(iv_seen));
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    check("R2 unexpected result", 64'd1, 64'd0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check({e.tag, " sum"},  64'(sum_bcd),   64'(e.sum));
                    check({e.tag, " cout"}, 64'(carry_out), 64'(e.cout));
                    last_sum  = e.sum;
                    last_cout = e.cout;
                    have_last = 1'b1;
                end
            end else if (have_last) begin
                check("R3 hold sum",  64'(sum_bcd),   64'(last_sum));
                check("R3 hold cout", 64'(carry_out), 64'(last_cout));
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset out_valid", 64'(out_valid), 64'd0);
        check("R1 reset sum",       64'(sum_bcd),   64'd0);
        check("R1 reset cout",      64'(carry_out), 64'd0);
        rst = 1'b0;

        drive(5, 3, 1'b0, "R4 5+3");
        drive(7, 6, 1'b0, "R5 7+6");
        drive(9, 9, 1'b1, "R5 9+9+1 above fifteen");
        drive(247, 538, 1'b0, "R6 247+538");
        idle(3);
        drive(999, 1, 1'b0, "R6 ripple 999+1");
        drive(0, 0, 1'b1, "R7 carry_in only");
        drive(9999, 0, 1'b1, "R7 R8 full ripple");
        drive(9999, 9999, 1'b1, "R8 max");
        drive(1, 0, 1'b0, "R9 digit0 low nibble");
        drive(1000, 0, 1'b0, "R9 top digit");
        drive(50, 50, 1'b0, "R6 middle carry");
        idle(2);
        for (int i = 0; i < 300; i++) begin
            drive((i * 7919 + 13) % 10000, (i * 4253 + 977) % 10000, 1'(i % 2), "R5 R6 sweep");
            if (i % 37 == 0) idle(1);
        end
        idle(3);

        // Reset while idle must clear the held result.
        @(posedge clk); #1;
        rst = 1'b1;
        have_last = 1'b0;
        @(posedge clk); #1;
        check("R1 mid reset sum",  64'(sum_bcd),   64'd0);
        check("R1 mid reset cout", 64'(carry_out), 64'd0);
        rst = 1'b0;
        idle(2);
        check("R2 queue drained", 64'(exp_q.size()), 64'd0);
        finish_run();
    end

endmodule